// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block maps a physical memory address onto one of eight DRAM rows. It keeps one programmable upper-limit register per row. Each register gives the cumulative size of that row and every row numbered below it, counted in 64 MB units. The top address bits form a 7-bit field, a zero followed by address bits 31:26. That field is compared against the limits to find the row that contains the address. The block reports the result three ways: a one-hot row select, an encoded row index and a hit flag.

Software loads the limits through a small byte-wide configuration port with 16 offsets. Offsets 0h to 7h hold the row limits and offsets 8h to Fh are reserved. A mode input chooses between two decodes. In dual-channel decode only rows 0 to 3 take part. In single-channel decode all eight rows take part, with rows 0 to 3 on the first channel and rows 4 to 7 on the second. A row whose limit equals the limit of the row below it is empty, so no address can land in it. The decode path is purely combinational. Register writes are clocked.

Top module: `row_bound_decoder`

## Requirements
- R1: After reset every limit register holds 01h. A read of any offset 0h to 7h returns 01h.
- R2: A write to offset 0h to 7h stores bits 6:0 of the write data on the rising clock edge on which the write strobe is high. A later read of that offset returns the stored value with bit 7 forced to zero.
- R3: A read of any offset 8h to Fh returns 00h. A write to those offsets changes no limit register.
- R4: The address field is {0, mem_addr[31:26]}. Row i is selected when the field is at least the limit of row i-1 and below the limit of row i. For row 0 the lower bound is zero.
- R5: When more than one row qualifies, the lowest-numbered row is selected. A row whose limit equals the limit of the row below it is never selected.
- R6: When no active row qualifies, row_hit is 0, row_sel is all zero and row_num is 0. This includes a field at or above the last active limit.
- R7: When dual_mode is 1, only rows 0 to 3 can be selected, whatever rows 4 to 7 hold.
- R8: When dual_mode is 0, all eight rows can be selected.
- R9: When row_hit is 1, row_sel has exactly one bit set and row_num is the index of that bit.
- R10: The decode outputs follow mem_addr and dual_mode within the same cycle. A limit write changes the decode only after the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the limit registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 4 | Configuration offset, used for both read and write |
| cfg_wdata | input | 8 | Write data; only bits 6:0 are stored |
| cfg_rdata | output | 8 | Read data for the offset on cfg_addr |
| dual_mode | input | 1 | 1 = dual-channel decode (rows 0-3), 0 = single-channel decode (rows 0-7) |
| mem_addr | input | 32 | Physical address to decode |
| row_sel | output | 8 | One-hot row select |
| row_num | output | 3 | Encoded row index, 0 on a miss |
| row_hit | output | 1 | Address falls inside an active row |

## Verification
A limit write and a decode of an address that the write moves across a row edge can happen in the same cycle. The bench holds mem_addr on such a field while it raises the write strobe. It then samples the decode twice. Before the edge the decode must still reflect the old limit, and after the edge it must reflect the new one. Randomly mixed writes, including writes to reserved offsets, and decodes under both modes are judged against a bench model of the limit table.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
   // decode variant driven by the mode pin
   typedef enum logic {
      RBD_SINGLE = 1'b0,
      RBD_DUAL   = 1'b1
   } rbd_mode_e;

   localparam int RBD_ROWS       = 8;
   localparam int RBD_BND_W      = 7;
   localparam int RBD_DATA_W     = 8;
   localparam int RBD_CFG_AW     = 4;
   localparam int RBD_ADDR_W     = 32;
   localparam int RBD_UNIT_SHIFT = 26;
   localparam logic [RBD_BND_W-1:0] RBD_RST_LIMIT = 7'h01;
endpackage

// File: rtl/rbd_regfile.sv
module rbd_regfile #(
   parameter int NUM_ROWS = 8,
   parameter int BND_W    = 7,
   parameter int DATA_W   = 8,
   parameter int CFG_AW   = 4,
   parameter logic [BND_W-1:0] RST_VAL = '0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            we,
   input  logic [CFG_AW-1:0]               addr,
   input  logic [DATA_W-1:0]               wdata,
   output logic [DATA_W-1:0]               rdata,
   output logic [NUM_ROWS-1:0][BND_W-1:0]  limits
);
   localparam int IDX_W = $clog2(NUM_ROWS);
   localparam logic [CFG_AW:0] ROWS_C = (CFG_AW+1)'(NUM_ROWS);

   logic in_map;
   logic [IDX_W-1:0] idx;

   assign in_map = ({1'b0, addr} < ROWS_C);
   assign idx    = addr[IDX_W-1:0];

   for (genvar g = 0; g < NUM_ROWS; g++) begin : g_lim
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            limits[g] <= RST_VAL;
         end else if (we && in_map && (idx == IDX_W'(g))) begin
            limits[g] <= wdata[BND_W-1:0];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (in_map) begin
         rdata[BND_W-1:0] = limits[idx];
      end
   end
endmodule

// File: rtl/rbd_row_match.sv
module rbd_row_match #(
   parameter int BND_W = 7
) (
   input  logic             enable,
   input  logic [BND_W-1:0] field,
   input  logic [BND_W-1:0] lower,
   input  logic [BND_W-1:0] upper,
   output logic             match
);
   logic above_lo;
   logic below_hi;

   assign above_lo = (field >= lower);
   assign below_hi = (field <  upper);
   assign match    = enable & above_lo & below_hi;
endmodule

// File: rtl/rbd_pick.sv
module rbd_pick #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     req,
   output logic [N-1:0]     sel,
   output logic [IDX_W-1:0] idx,
   output logic             hit
);
   // scan from the top so the lowest requesting row is the last one kept
   always_comb begin
      sel = '0;
      idx = '0;
      hit = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            sel    = '0;
            sel[i] = 1'b1;
            idx    = IDX_W'(i);
            hit    = 1'b1;
         end
      end
   end
endmodule

// File: rtl/row_bound_decoder.sv
module row_bound_decoder
   import rbd_pkg::*;
#(
   parameter int NUM_ROWS   = RBD_ROWS,
   parameter int BND_W      = RBD_BND_W,
   parameter int DATA_W     = RBD_DATA_W,
   parameter int CFG_AW     = RBD_CFG_AW,
   parameter int ADDR_W     = RBD_ADDR_W,
   parameter int UNIT_SHIFT = RBD_UNIT_SHIFT,
   parameter logic [BND_W-1:0] RST_LIMIT = RBD_RST_LIMIT
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_we,
   input  logic [CFG_AW-1:0]           cfg_addr,
   input  logic [DATA_W-1:0]           cfg_wdata,
   output logic [DATA_W-1:0]           cfg_rdata,
   input  logic                        dual_mode,
   input  logic [ADDR_W-1:0]           mem_addr,
   output logic [NUM_ROWS-1:0]         row_sel,
   output logic [$clog2(NUM_ROWS)-1:0] row_num,
   output logic                        row_hit
);
   localparam int IDX_W     = $clog2(NUM_ROWS);
   localparam int FIELD_W   = ADDR_W - UNIT_SHIFT;
   localparam int DUAL_ROWS = NUM_ROWS / 2;

   // elaboration-time parameter checks
   if (NUM_ROWS < 2 || (1 << IDX_W) != NUM_ROWS) begin : g_bad_rows
      $error("row count must be a power of two of at least 2");
   end
   if (BND_W <= FIELD_W) begin : g_bad_field
      $error("limit width must exceed the address field width");
   end
   if (DATA_W < BND_W || (1 << CFG_AW) < NUM_ROWS) begin : g_bad_cfg
      $error("configuration port too narrow for the limit table");
   end

   rbd_mode_e                      mode;
   logic [BND_W-1:0]               field;
   logic [NUM_ROWS-1:0][BND_W-1:0] limit_q;
   logic [NUM_ROWS-1:0]            row_req;

   assign mode  = rbd_mode_e'(dual_mode);
   assign field = {{(BND_W-FIELD_W){1'b0}}, mem_addr[ADDR_W-1:UNIT_SHIFT]};

   rbd_regfile #(
      .NUM_ROWS (NUM_ROWS),
      .BND_W    (BND_W),
      .DATA_W   (DATA_W),
      .CFG_AW   (CFG_AW),
      .RST_VAL  (RST_LIMIT)
   ) i_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .addr   (cfg_addr),
      .wdata  (cfg_wdata),
      .rdata  (cfg_rdata),
      .limits (limit_q)
   );

   for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
      logic [BND_W-1:0] lo;
      logic             en;
      if (g == 0) begin : g_base
         assign lo = '0;
      end else begin : g_chain
         assign lo = limit_q[g-1];
      end
      if (g < DUAL_ROWS) begin : g_always
         assign en = 1'b1;
      end else begin : g_single_only
         assign en = (mode == RBD_SINGLE);
      end
      rbd_row_match #(.BND_W(BND_W)) i_match (
         .enable (en),
         .field  (field),
         .lower  (lo),
         .upper  (limit_q[g]),
         .match  (row_req[g])
      );
   end

   rbd_pick #(.N(NUM_ROWS), .IDX_W(IDX_W)) i_pick (
      .req (row_req),
      .sel (row_sel),
      .idx (row_num),
      .hit (row_hit)
   );
endmodule

// File: rtl/rbd_checker.sv
module rbd_checker #(
   parameter int NUM_ROWS = 8,
   parameter int BND_W    = 7,
   parameter int DATA_W   = 8,
   parameter int CFG_AW   = 4,
   parameter int IDX_W    = 3
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           cfg_we,
   input logic [CFG_AW-1:0]              cfg_addr,
   input logic [DATA_W-1:0]              cfg_wdata,
   input logic [DATA_W-1:0]              cfg_rdata,
   input logic                           dual_mode,
   input logic [BND_W-1:0]               field,
   input logic [NUM_ROWS-1:0][BND_W-1:0] limit_q,
   input logic [NUM_ROWS-1:0]            row_sel,
   input logic [IDX_W-1:0]               row_num,
   input logic                           row_hit
);
   localparam int DUAL_ROWS = NUM_ROWS / 2;
   localparam logic [CFG_AW:0] ROWS_C = (CFG_AW+1)'(NUM_ROWS);

   logic             in_map;
   logic [IDX_W-1:0] cfg_idx;
   logic [BND_W-1:0] hit_lo;

   assign in_map  = ({1'b0, cfg_addr} < ROWS_C);
   assign cfg_idx = cfg_addr[IDX_W-1:0];
   assign hit_lo  = (row_num == '0) ? '0 : limit_q[row_num - IDX_W'(1)];

   assert_write_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && in_map) |=> (limit_q[$past(cfg_idx)] == $past(cfg_wdata[BND_W-1:0])));

   assert_rsvd_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !in_map |-> (cfg_rdata == '0));

   assert_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      row_hit |-> ((field < limit_q[row_num]) && (field >= hit_lo)));

   assert_miss_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !row_hit |-> ((row_sel == '0) && (row_num == '0)));

   assert_dual_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dual_mode |-> (row_sel[NUM_ROWS-1:DUAL_ROWS] == '0));

   assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      row_hit |-> ($onehot0(row_sel) && row_sel[row_num]));
endmodule

bind row_bound_decoder rbd_checker #(
   .NUM_ROWS (NUM_ROWS),
   .BND_W    (BND_W),
   .DATA_W   (DATA_W),
   .CFG_AW   (CFG_AW),
   .IDX_W    (IDX_W)
) i_rbd_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_addr  (cfg_addr),
   .cfg_wdata (cfg_wdata),
   .cfg_rdata (cfg_rdata),
   .dual_mode (dual_mode),
   .field     (field),
   .limit_q   (limit_q),
   .row_sel   (row_sel),
   .row_num   (row_num),
   .row_hit   (row_hit)
);

// File: tb/test_row_bound_decoder.sv
module test_row_bound_decoder;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic        dual_mode = 1'b0;
   logic [31:0] mem_addr = '0;
   logic [7:0]  row_sel;
   logic [2:0]  row_num;
   logic        row_hit;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   int bm [8];

   always #(CLK_PERIOD/2) clk = ~clk;

   row_bound_decoder i_row_bound_decoder (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dual_mode(dual_mode),
      .mem_addr(mem_addr), .row_sel(row_sel), .row_num(row_num), .row_hit(row_hit)
   );

   function automatic int exp_row(int f, bit dual);
      int n = dual ? 4 : 8;
      for (int i = 0; i < n; i++) begin
         int lo = (i == 0) ? 0 : bm[i-1];
         if (f >= lo && f < bm[i]) return i;
      end
      return -1;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   task automatic wr(int a, int d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 8'(d);
      @(posedge clk);
      #1;
      cfg_we = 1'b0;
      if (a < 8) bm[a] = d & 8'h7f;
   endtask

   task automatic chk_rd(int a, string tag);
      int e = (a < 8) ? bm[a] : 0;
      @(negedge clk);
      cfg_addr = 4'(a);
      #1;
      n_checks++;
      if (int'(cfg_rdata) != e) begin
         n_fail++;
         $display("FAIL %s read offset %0d: got %02h expected %02h", tag, a, cfg_rdata, e);
      end
   endtask

   task automatic sample_dec(string tag);
      int e = exp_row(int'(mem_addr[31:26]), dual_mode);
      logic [7:0] es = (e < 0) ? 8'h00 : 8'(1 << e);
      int en = (e < 0) ? 0 : e;
      n_checks++;
      if (row_hit != (e >= 0) || row_sel != es || int'(row_num) != en) begin
         n_fail++;
         $display("FAIL %s addr %08h dual %0b: got hit %0b sel %02h num %0d expected hit %0b sel %02h num %0d",
                  tag, mem_addr, dual_mode, row_hit, row_sel, row_num, e >= 0, es, en);
      end
   endtask

   task automatic chk_dec(logic [31:0] a, bit dual, string tag);
      @(negedge clk);
      mem_addr = a; dual_mode = dual;
      #1;
      sample_dec(tag);
   endtask

   function automatic logic [31:0] fa(int f);
      return {6'(f), 26'($urandom)};
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      for (int i = 0; i < 8; i++) bm[i] = 1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      for (int i = 0; i < 8; i++) chk_rd(i, "R1");
      chk_dec(fa(0), 0, "R1 R4");
      chk_dec(fa(1), 0, "R1 R6");

      // R2 bit 7 dropped on write
      wr(2, 8'hff);
      chk_rd(2, "R2");
      // R3 reserved offsets
      wr(9, 8'h55);
      wr(15, 8'h7f);
      chk_rd(9, "R3");
      chk_rd(15, "R3");
      for (int i = 0; i < 8; i++) chk_rd(i, "R3 untouched");

      // R7 R8: full 4 GB in dual mode, rows 4-7 repeat row 3
      wr(0, 8'h10); wr(1, 8'h20); wr(2, 8'h30); wr(3, 8'h40);
      for (int i = 4; i < 8; i++) wr(i, 8'h40);
      chk_dec(32'hffff_ffff, 1, "R7");
      chk_dec(32'h0000_0000, 1, "R4");
      chk_dec(32'h4000_0000, 1, "R4 edge");
      chk_dec(32'h3fff_ffff, 1, "R4 edge");
      chk_dec(32'hffff_ffff, 0, "R8");

      // R5 zero-size rows, R8 upper rows reachable, R6 above top
      wr(0, 8'h08); wr(1, 8'h08); wr(2, 8'h10); wr(3, 8'h10);
      wr(4, 8'h18); wr(5, 8'h20); wr(6, 8'h20); wr(7, 8'h28);
      chk_dec(fa(8), 0, "R5");
      chk_dec(fa(7), 0, "R5");
      chk_dec(fa(16), 0, "R5 R8");
      chk_dec(fa(32), 0, "R8");
      chk_dec(fa(40), 0, "R6");
      chk_dec(fa(16), 1, "R6 R7");

      // R10 write and decode in the same cycle
      @(negedge clk);
      mem_addr = fa(8); dual_mode = 1'b0;
      cfg_we = 1'b1; cfg_addr = 4'd1; cfg_wdata = 8'h0c;
      #1;
      sample_dec("R10 before edge");
      @(posedge clk);
      #1;
      cfg_we = 1'b0;
      bm[1] = 8'h0c;
      sample_dec("R10 after edge");
      chk_dec(fa(12), 0, "R10");

      // random mix: monotone tables, raw writes, decodes and reads
      for (int it = 0; it < 400; it++) begin
         int k = int'($urandom_range(0, 19));
         if (k == 0) begin
            int acc = 0;
            for (int r = 0; r < 8; r++) begin
               acc = acc + int'($urandom_range(0, 14));
               if (acc > 127) acc = 127;
               wr(r, acc | (int'($urandom_range(0, 1)) << 7));
            end
         end else if (k < 3) begin
            wr(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)));
         end else if (k < 5) begin
            chk_rd(int'($urandom_range(0, 15)), "R2 R3 random");
         end else begin
            chk_dec($urandom, 1'($urandom), "R4 R5 R9 random");
         end
      end
      for (int i = 0; i < 16; i++) chk_rd(i, "R2 R3 final");

      finish_run();
   end
endmodule